// File: doc/BRIEF.md
# DRAM Power-Up and CAS-Before-RAS Refresh Sequencer

This block owns the refresh duties of an asynchronous DRAM array. When reset is released it waits out the power-up pause the memory needs. Then it runs a burst of eight warm-up refresh cycles. After the burst it raises a sticky ready flag and starts issuing periodic CAS-before-RAS refresh cycles. These cycles come often enough to sweep 4096 rows in 64 ms: the default is one every 1560 clocks at 100 MHz. Because the memory steps its own internal row counter in this mode, the block never produces a row address.

The block shares the RAS, CAS and write-enable strobes with the normal access controller through a request/grant pair. It raises `req_o` while it owes at least one refresh or while a cycle is still running. It starts a new cycle only on a clock edge where `grant_i` is high. The access controller multiplexes the block's strobes onto the memory while it grants. Intervals that pass without a grant are counted, up to a cap of eight. Once the grant arrives, the owed cycles are replayed back to back.

Each refresh cycle follows this sequence:
1. CAS falls first.
2. RAS follows a set number of clocks later and stays low for a minimum time.
3. RAS is released.
4. CAS is released one clock after RAS.
5. A precharge gap follows before the next cycle.

Write-enable stays high throughout, which meets the setup and hold rule around the RAS fall.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, `ready_o` and `req_o` are 0 and `ras_n_o`, `cas_n_o` and `we_n_o` are 1.
- R2: No strobe falls before PAUSE_US*CLK_MHZ clock cycles have passed since reset was released.
- R3: After the pause, exactly WARMUP_N (default 8) refresh cycles run, and `ready_o` rises on the clock edge that ends the last of them.
- R4: In each refresh cycle, `cas_n_o` is low for exactly CAS_LEAD cycles before `ras_n_o` falls.
- R5: `ras_n_o` stays low for exactly RAS_LOW cycles and rises while `cas_n_o` is still low. `cas_n_o` rises one cycle later.
- R6: `we_n_o` is 1 at all times, including the cycle before and the cycles during each RAS-low window.
- R7: Once ready, with the grant held high, successive RAS falls are exactly REF_INTERVAL cycles apart (default 1560, about 15.6 µs at 100 MHz).
- R8: Successive RAS falls are never closer than CAS_LEAD+RAS_LOW+PRE_CYC+2 cycles. This covers the full RAS cycle time of either speed grade.
- R9: A refresh cycle (CAS fall) begins only on a clock edge where `grant_i` is 1. With the grant held low, no strobe moves.
- R10: `req_o` is 1 while any refresh is owed or a cycle is in progress. Each interval that passes without service adds one owed refresh. When granted, all owed refreshes are run.
- R11: The owed count saturates at MISS_MAX (default 8). Owed cycles run back to back, RAS falls spaced exactly CAS_LEAD+RAS_LOW+PRE_CYC+2 cycles apart.
- R12: Once `ready_o` has risen it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| grant_i | input | 1 | Access controller hands the strobes to this block |
| req_o | output | 1 | Refresh owed or in progress |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write-enable, held high |
| ready_o | output | 1 | Pause and warm-up done, memory usable |

## Verification
The sequencer is driven with four grant patterns:
- **Grant held high from reset.** This exposes the pause length, the warm-up count and the strobe ordering.
- **Grant held high in steady state.** This separates the periodic interval from the back-to-back slot length.
- **Grant withheld for two intervals.** The replay must deliver exactly three cycles, which shows that missed intervals are counted.
- **Grant withheld for more than eight intervals.** The replay must deliver exactly eight closely spaced cycles, which tells saturation apart from plain accumulation.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CAS,
    PH_RAS,
    PH_REL,
    PH_PRE
  } phase_e;

  function automatic int pause_cycles(input int us, input int mhz);
    return us * mhz;
  endfunction

  // start-to-start distance of two refreshes issued back to back
  function automatic int slot_cycles(input int lead, input int low, input int pre);
    return lead + low + pre + 2;
  endfunction

endpackage

// File: rtl/dram_ref_pause.sv
module dram_ref_pause #(
  parameter int CYCLES = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic expire_o,
  output logic done_o
);
  localparam int PW = $clog2(CYCLES + 1);
  localparam logic [PW-1:0] LAST = PW'(CYCLES - 1);

  logic [PW-1:0] cnt_q;
  logic          done_q;

  assign expire_o = !done_q && (cnt_q == LAST);
  assign done_o   = done_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (expire_o) begin
      done_q <= 1'b1;
    end else if (!done_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dram_ref_ticker.sv
module dram_ref_ticker #(
  parameter int INTERVAL = 1560
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int TW = $clog2(INTERVAL + 1);
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !en_i || tick_o) cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dram_ref_strobe.sv
module dram_ref_strobe
  import dram_ref_pkg::*;
#(
  parameter int CAS_LEAD = 2,
  parameter int RAS_LOW  = 5,
  parameter int PRE_CYC  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic busy_o,
  output logic done_o
);
  localparam int MAXP = (CAS_LEAD > RAS_LOW)
                        ? ((CAS_LEAD > PRE_CYC) ? CAS_LEAD : PRE_CYC)
                        : ((RAS_LOW  > PRE_CYC) ? RAS_LOW  : PRE_CYC);
  localparam int CW = $clog2(MAXP + 1);

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic          last_w;

  function automatic logic [CW-1:0] phase_lim(input phase_e p);
    case (p)
      PH_CAS:  return CW'(CAS_LEAD - 1);
      PH_RAS:  return CW'(RAS_LOW - 1);
      PH_PRE:  return CW'(PRE_CYC - 1);
      default: return '0;
    endcase
  endfunction

  function automatic phase_e phase_after(input phase_e p);
    case (p)
      PH_CAS:  return PH_RAS;
      PH_RAS:  return PH_REL;
      PH_REL:  return PH_PRE;
      default: return PH_IDLE;
    endcase
  endfunction

  assign last_w  = (cnt_q == phase_lim(ph_q));
  assign cas_n_o = !(ph_q == PH_CAS || ph_q == PH_RAS || ph_q == PH_REL);
  assign ras_n_o = !(ph_q == PH_RAS);
  assign busy_o  = (ph_q != PH_IDLE);
  assign done_o  = (ph_q == PH_PRE) && last_w;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (ph_q == PH_IDLE) begin
      cnt_q <= '0;
      if (start_i) ph_q <= PH_CAS;
    end else if (last_w) begin
      ph_q  <= phase_after(ph_q);
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int CLK_MHZ      = 100,
  parameter int PAUSE_US     = 200,
  parameter int REF_INTERVAL = 1560,
  parameter int WARMUP_N     = 8,
  parameter int MISS_MAX     = 8,
  parameter int CAS_LEAD     = 2,
  parameter int RAS_LOW      = 5,
  parameter int PRE_CYC      = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  output logic req_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic ready_o
);
  localparam int PAUSE_CYC = pause_cycles(PAUSE_US, CLK_MHZ);
  localparam int OW        = $clog2(MISS_MAX + 1);
  localparam int WW        = $clog2(WARMUP_N + 1);

  logic          pause_expire_w, pause_done_w;
  logic          tick_w, busy_w, done_w, start_w;
  logic [OW-1:0] owed_q;
  logic [WW-1:0] warm_q;
  logic          ready_q;

  function automatic logic [OW-1:0] owed_next(input logic [OW-1:0] cur,
                                              input logic up, input logic dn);
    logic [OW:0] s;
    s = {1'b0, cur} + {{OW{1'b0}}, up} - {{OW{1'b0}}, dn};
    if (s > (OW+1)'(MISS_MAX)) return OW'(MISS_MAX);
    return s[OW-1:0];
  endfunction

  dram_ref_pause #(.CYCLES(PAUSE_CYC)) u_pause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .expire_o(pause_expire_w),
    .done_o  (pause_done_w)
  );

  dram_ref_ticker #(.INTERVAL(REF_INTERVAL)) u_ticker (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ready_q),
    .tick_o(tick_w)
  );

  dram_ref_strobe #(.CAS_LEAD(CAS_LEAD), .RAS_LOW(RAS_LOW), .PRE_CYC(PRE_CYC)) u_strobe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_w),
    .ras_n_o(ras_n_o),
    .cas_n_o(cas_n_o),
    .busy_o (busy_w),
    .done_o (done_w)
  );

  assign start_w = pause_done_w && (owed_q != '0) && grant_i && !busy_w;
  assign req_o   = (owed_q != '0) || busy_w;
  assign we_n_o  = 1'b1;
  assign ready_o = ready_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      owed_q  <= '0;
      warm_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      if (pause_expire_w) owed_q <= OW'(WARMUP_N);
      else                owed_q <= owed_next(owed_q, tick_w, done_w);
      if (!ready_q && done_w) begin
        warm_q <= warm_q + 1'b1;
        if (warm_q == WW'(WARMUP_N - 1)) ready_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int MISS_MAX = 8,
  parameter int OW       = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          grant_i,
  input logic          ras_n_o,
  input logic          cas_n_o,
  input logic          ready_o,
  input logic [OW-1:0] owed_i
);
  assert_cas_leads_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (!cas_n_o && !$past(cas_n_o)));

  assert_ras_first_up_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> !cas_n_o);

  assert_cas_after_ras_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_n_o) |-> (ras_n_o && $past(ras_n_o)));

  assert_grant_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_n_o) && ras_n_o) |-> $past(grant_i));

  assert_owed_cap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owed_i <= OW'(MISS_MAX));

  assert_ready_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(.MISS_MAX(MISS_MAX), .OW(OW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .grant_i(grant_i),
  .ras_n_o(ras_n_o),
  .cas_n_o(cas_n_o),
  .ready_o(ready_o),
  .owed_i (owed_q)
);

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb;
  localparam int PAUSE_CYC = 100;   // PAUSE_US=1 at 100 MHz
  localparam int REF_INT   = 200;
  localparam int LEAD      = 2;
  localparam int LOW       = 5;
  localparam int PRE       = 4;
  localparam int WARM      = 8;
  localparam int MAXM      = 8;
  localparam int SLOT      = LEAD + LOW + PRE + 2;

  logic clk = 1'b0, rst_n = 1'b0, grant = 1'b0;
  logic req, ras_n, cas_n, we_n, ready;

  always #5 clk = ~clk;

  dram_refresh_seq #(.CLK_MHZ(100), .PAUSE_US(1), .REF_INTERVAL(REF_INT), .WARMUP_N(WARM),
    .MISS_MAX(MAXM), .CAS_LEAD(LEAD), .RAS_LOW(LOW), .PRE_CYC(PRE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .grant_i(grant), .req_o(req),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .ready_o(ready));

  int n_chk = 0, n_bad = 0, wd = 0;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // monitor, sampled at falling edges
  int cyc = 0, ras_falls = 0, first_cas = -1, last_fall = -1, gap_last = 0;
  int min_gap = 1000000, lead_run = 0, last_lead = 0, low_run = 0, last_low = 0;
  int order_bad = 0, we_bad = 0, ready_drop = 0, nogrant = 0;
  bit p_ras = 1'b1, p_cas = 1'b1, p_ready = 1'b0, g_edge = 1'b0;

  always @(posedge clk) g_edge <= grant;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (p_cas && !cas_n) begin
        if (first_cas < 0) first_cas = cyc;
        if (!g_edge) nogrant++;
      end
      if (cas_n) lead_run = 0;
      else if (ras_n && p_ras) lead_run++;
      if (p_ras && !ras_n) begin
        ras_falls++;
        last_lead = lead_run;
        lead_run  = 0;
        if (last_fall >= 0) begin
          gap_last = cyc - last_fall;
          if (gap_last < min_gap) min_gap = gap_last;
        end
        last_fall = cyc;
      end
      if (!ras_n) low_run++;
      if (!p_ras && ras_n) begin
        last_low = low_run;
        low_run  = 0;
        if (cas_n) order_bad++;
      end
      if (!p_cas && cas_n && !ras_n) order_bad++;
      if (!we_n) we_bad++;
      if (p_ready && !ready) ready_drop++;
      p_ras = ras_n; p_cas = cas_n; p_ready = ready;
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
      finish_run();
    end
  end

  task automatic t_reset();
    rst_n = 1'b0; grant = 1'b0;
    repeat (5) @(negedge clk);
    check(ready == 1'b0, "R1 ready", ready, 0);
    check(req == 1'b0, "R1 req", req, 0);
    check({ras_n, cas_n, we_n} == 3'b111, "R1 strobes", {ras_n, cas_n, we_n}, 7);
    #1 rst_n = 1'b1;
  endtask

  task automatic t_init();
    @(negedge clk); #1 grant = 1'b1;
    for (int i = 0; i < 3000 && !ready; i++) @(negedge clk);
    check(ready == 1'b1, "R3 ready rose", ready, 1);
    check(first_cas >= PAUSE_CYC, "R2 pause", first_cas, PAUSE_CYC);
    check(ras_falls == WARM, "R3 warm-up count", ras_falls, WARM);
    check(last_lead == LEAD, "R4 cas lead", last_lead, LEAD);
    check(last_low == LOW, "R5 ras low width", last_low, LOW);
    check(order_bad == 0, "R5 release order", order_bad, 0);
    check(min_gap == SLOT, "R8 warm-up spacing", min_gap, SLOT);
  endtask

  task automatic t_periodic();
    int f0 = ras_falls;
    for (int i = 0; i < 5 * REF_INT && ras_falls < f0 + 3; i++) @(negedge clk);
    check(ras_falls == f0 + 3, "R7 periodic refreshes", ras_falls - f0, 3);
    check(gap_last == REF_INT, "R7 interval", gap_last, REF_INT);
    check(last_lead == LEAD, "R4 periodic cas lead", last_lead, LEAD);
  endtask

  task automatic t_starve(input int wait_cyc, input int expect_n, input string rq);
    int f0;
    for (int i = 0; i < 2 * REF_INT && req; i++) @(negedge clk);
    for (int i = 0; i < 2 * REF_INT && !req; i++) @(negedge clk);
    #1 grant = 1'b0;
    f0 = ras_falls;
    repeat (wait_cyc) @(negedge clk);
    check(ras_falls == f0, "R9 no cycle without grant", ras_falls - f0, 0);
    check(cas_n == 1'b1, "R9 cas idle without grant", cas_n, 1);
    check(req == 1'b1, "R10 request held", req, 1);
    #1 grant = 1'b1;
    repeat (expect_n * SLOT + 20) @(negedge clk);
    check(ras_falls - f0 == expect_n, rq, ras_falls - f0, expect_n);
    check(gap_last == SLOT, "R11 back-to-back spacing", gap_last, SLOT);
    check(req == 1'b0, "R10 request dropped", req, 0);
  endtask

  initial begin
    t_reset();
    t_init();
    t_periodic();
    t_starve(2 * REF_INT + 50, 3, "R10 missed intervals replayed");
    t_starve(9 * REF_INT - 150, MAXM, "R11 saturated replay");
    check(nogrant == 0, "R9 cas fall needs grant", nogrant, 0);
    check(we_bad == 0, "R6 write-enable high", we_bad, 0);
    check(ready_drop == 0 && ready == 1'b1, "R12 ready sticky", ready_drop, 0);
    check(min_gap >= SLOT, "R8 minimum spacing", min_gap, SLOT);
    finish_run();
  end
endmodule